// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block is the register front end of a command-response buffer interface to a security coprocessor. Software reaches it through a byte-addressed write port carrying one- to four-byte little-endian values and a combinational read port. Address bits 11:0 select a register inside a 4 KiB page. The bits above bit 11 name the locality that issues the access.

Software requests the interface for a locality, moves the coprocessor out of idle, and then starts a command. The block tells the back end through a one-cycle deliver pulse. Software may cancel a command that is in flight, which sends a one-cycle cancel pulse. The back end ends each command with a completion pulse that carries an error flag. The block also reports fixed identification and capability values and the location and size of the shared data buffer. It does no command processing and does not hold the buffer contents.

Top module: `crb_ctrl_regs`

## Requirements
- R1: After reset the registers read as follows.
  - Locality state (offset 0x000) is 0x80: bit 7 is register-valid, bit 1 is assigned, bits 6:4 are the active locality, and bit 0 is explained in R9.
  - Locality status (0x00C) is 0, with bit 0 granted and bit 1 been-seized.
  - Control status (0x044) is 0x2, with bit 1 idle and bit 0 fatal error.
  - Start (0x04C) is 0.
  - Interface identity (0x030) is 0x00025811.
  - Command and response size (0x058, 0x064) both read WIN_SIZE-BUF_OFFSET, which is 0xF80.
  - Command and response address (0x05C, 0x068) both read WIN_BASE+BUF_OFFSET, which is 0x80000080.
- R2: A write of 1 to control request (0x040) clears the idle bit. A write of 2 sets it. Any other value leaves control status unchanged.
- R3: Locality control (0x008) acts on the value written.
  - Value 1 sets granted and assigned and clears been-seized.
  - Value 2 clears granted and assigned.
  - Values 4 and 8, and any other value, change nothing.
- R4: A write to start (0x04C) is accepted only if all of these hold: the value is exactly 1, the start bit is clear, and the active locality equals the write address bits above bit 11. An accepted start sets the start bit. It also raises the deliver output for exactly one cycle, starting on the clock edge that takes the write.
- R5: A write of 1 to cancel (0x048) raises the cancel output for one cycle only while the start bit is set. At any other time, or with any other value, the cancel output stays low.
- R6: A completion pulse clears the start bit. If the error flag is set with the completion, the fatal-error bit is set and stays set until reset.
- R7: The active locality counts as none (0xFF) while assigned is clear. Once assigned, it is the active-locality field, which is always 0. A start from any other locality page is therefore rejected.
- R8: A read returns the aligned 32-bit register shifted right by 8 times the address bits 1:0.
- R9: Bit 0 of the locality state reads as the inverse of the established-flag input.
- R10: Writes to the identity, size and address registers are ignored. Reads of unmapped offsets return 0.
- R11: The written value is the write data masked to 8, 16, 24 or 32 bits by busWrSize (0 to 3). Only the masked value is compared against command codes.
- R12: A start write in the same cycle as a completion pulse is rejected: no deliver pulse, and the start bit stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busAddr | input | ADDR_W | Byte address; bits above 11 carry the locality |
| busWrData | input | 32 | Write data, low bytes significant |
| busWrSize | input | 2 | Write size in bytes minus one |
| busRdData | output | 32 | Combinational read data for busAddr |
| estFlag | input | 1 | Established flag from the back end |
| deliverCmd | output | 1 | One-cycle command delivery pulse |
| cancelCmd | output | 1 | One-cycle cancel pulse |
| cmdDone | input | 1 | Back-end completion pulse |
| cmdErr | input | 1 | Error flag qualified by cmdDone |

## Verification
A wrong start bit shows up within one cycle in two ways. A second deliver pulse appears, or a legal cancel fails to pulse, and the start register reads back wrong. Wrong locality or idle state is visible in the status words read right after the write. A broken owner compare lets a foreign locality page produce a deliver pulse. Byte-lane and size-mask faults show up in shifted reads of the constant identity word and in masked command codes that are accepted or rejected when they should not be.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int DATA_W = 32;

  localparam logic [11:0] OFF_LOC_STATE = 12'h000;
  localparam logic [11:0] OFF_LOC_CTRL  = 12'h008;
  localparam logic [11:0] OFF_LOC_STS   = 12'h00C;
  localparam logic [11:0] OFF_IF_ID     = 12'h030;
  localparam logic [11:0] OFF_CTRL_REQ  = 12'h040;
  localparam logic [11:0] OFF_CTRL_STS  = 12'h044;
  localparam logic [11:0] OFF_CANCEL    = 12'h048;
  localparam logic [11:0] OFF_START     = 12'h04C;
  localparam logic [11:0] OFF_CMD_SIZE  = 12'h058;
  localparam logic [11:0] OFF_CMD_ADDR  = 12'h05C;
  localparam logic [11:0] OFF_RSP_SIZE  = 12'h064;
  localparam logic [11:0] OFF_RSP_ADDR  = 12'h068;

  localparam logic [DATA_W-1:0] VAL_READY   = 32'd1;
  localparam logic [DATA_W-1:0] VAL_IDLE    = 32'd2;
  localparam logic [DATA_W-1:0] VAL_GRANT   = 32'd1;
  localparam logic [DATA_W-1:0] VAL_RELEASE = 32'd2;
  localparam logic [DATA_W-1:0] VAL_INVOKE  = 32'd1;

  localparam logic [7:0] NO_OWNER = 8'hFF;

  typedef struct packed {
    logic goReady;
    logic goIdle;
    logic locGrant;
    logic locRelease;
    logic startCmd;
  } ctrlStrobes_t;
endpackage

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [1:0]         busWrSize,
  input  logic               startBit,
  input  logic               locAssigned,
  input  logic [2:0]         activeLoc,
  input  logic               cmdDone,
  output ctrlStrobes_t       strobes,
  output logic               deliverCmd,
  output logic               cancelCmd
);
  localparam int LOC_W = ADDR_W - 12;

  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] wrValue;
  logic [11:0]       offset;
  logic [7:0]        reqLoc;
  logic [7:0]        ownerLoc;
  logic              cancelHit;

  always_comb begin
    case (busWrSize)
      2'd0:    sizeMask = 32'h0000_00FF;
      2'd1:    sizeMask = 32'h0000_FFFF;
      2'd2:    sizeMask = 32'h00FF_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
  end

  assign wrValue  = busWrData & sizeMask;
  assign offset   = busAddr[11:0];
  assign reqLoc   = 8'(busAddr[ADDR_W-1:ADDR_W-LOC_W]);
  assign ownerLoc = locAssigned ? {5'd0, activeLoc} : NO_OWNER;

  always_comb begin
    strobes.goReady    = busWrEn && offset == OFF_CTRL_REQ && wrValue == VAL_READY;
    strobes.goIdle     = busWrEn && offset == OFF_CTRL_REQ && wrValue == VAL_IDLE;
    strobes.locGrant   = busWrEn && offset == OFF_LOC_CTRL && wrValue == VAL_GRANT;
    strobes.locRelease = busWrEn && offset == OFF_LOC_CTRL && wrValue == VAL_RELEASE;
    strobes.startCmd   = busWrEn && offset == OFF_START && wrValue == VAL_INVOKE &&
                         !startBit && !cmdDone && ownerLoc == reqLoc;
  end

  assign cancelHit = busWrEn && offset == OFF_CANCEL && wrValue == VAL_INVOKE && startBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deliverCmd <= 1'b0;
      cancelCmd  <= 1'b0;
    end else begin
      deliverCmd <= strobes.startCmd;
      cancelCmd  <= cancelHit;
    end
  end

  // R4: deliver lasts one cycle only
  assert_deliver_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    deliverCmd |=> !deliverCmd);
  // R5: a cancel pulse needs a command in flight at the write
  assert_cancel_inflight_R5: assert property (@(posedge clk) disable iff (!rstN)
    cancelCmd |-> $past(startBit));
  // R7: no start while nobody owns the interface
  assert_start_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startCmd |-> locAssigned);
endmodule

// File: rtl/crb_regs.sv
module crb_regs
  import crb_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0000_1000,
  parameter logic [31:0] BUF_OFFSET = 32'h0000_0080,
  parameter logic [3:0]  IF_REV     = 4'd0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               cmdDone,
  input  logic               cmdErr,
  input  logic               estFlag,
  input  logic [11:0]        rdOffset,
  output logic [DATA_W-1:0]  busRdData,
  output logic               startBit,
  output logic               locAssigned,
  output logic [2:0]         activeLoc
);
  localparam logic [31:0] BUF_SIZE = WIN_SIZE - BUF_OFFSET;
  localparam logic [31:0] BUF_ADDR = WIN_BASE + BUF_OFFSET;

  logic idleBit;
  logic fatalErr;
  logic granted;
  logic beenSeized;
  logic [DATA_W-1:0] ifIdWord;
  logic [DATA_W-1:0] wordSel;

  assign activeLoc = 3'd0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit    <= 1'b0;
      idleBit     <= 1'b1;
      fatalErr    <= 1'b0;
      locAssigned <= 1'b0;
      granted     <= 1'b0;
      beenSeized  <= 1'b0;
    end else begin
      if (cmdDone)               startBit <= 1'b0;
      else if (strobes.startCmd) startBit <= 1'b1;
      if (cmdDone && cmdErr)     fatalErr <= 1'b1;
      if (strobes.goReady)       idleBit  <= 1'b0;
      else if (strobes.goIdle)   idleBit  <= 1'b1;
      if (strobes.locGrant) begin
        granted     <= 1'b1;
        beenSeized  <= 1'b0;
        locAssigned <= 1'b1;
      end else if (strobes.locRelease) begin
        granted     <= 1'b0;
        locAssigned <= 1'b0;
      end
    end
  end

  always_comb begin
    ifIdWord        = '0;
    ifIdWord[3:0]   = 4'd1;
    ifIdWord[7:4]   = 4'd1;
    ifIdWord[8]     = 1'b0;
    ifIdWord[9]     = 1'b0;
    ifIdWord[12:11] = 2'b11;
    ifIdWord[13]    = 1'b0;
    ifIdWord[14]    = 1'b1;
    ifIdWord[18:17] = 2'd1;
    ifIdWord[27:24] = IF_REV;
  end

  always_comb begin
    case ({rdOffset[11:2], 2'b00})
      OFF_LOC_STATE: wordSel = {24'd0, 1'b1, activeLoc, 2'b00, locAssigned, !estFlag};
      OFF_LOC_STS:   wordSel = {30'd0, beenSeized, granted};
      OFF_IF_ID:     wordSel = ifIdWord;
      OFF_CTRL_STS:  wordSel = {30'd0, idleBit, fatalErr};
      OFF_START:     wordSel = {31'd0, startBit};
      OFF_CMD_SIZE:  wordSel = BUF_SIZE;
      OFF_CMD_ADDR:  wordSel = BUF_ADDR;
      OFF_RSP_SIZE:  wordSel = BUF_SIZE;
      OFF_RSP_ADDR:  wordSel = BUF_ADDR;
      default:       wordSel = '0;
    endcase
  end

  assign busRdData = wordSel >> {rdOffset[1:0], 3'b000};

  // R6: completion clears the start bit
  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !startBit);
  // R6: an error completion leaves fatal set
  assert_err_fatal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && cmdErr) |=> fatalErr);
  // R4: an accepted start sets the start bit
  assert_start_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startCmd |=> startBit);
  // R3: grant and release land in the locality state
  assert_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.locGrant |=> (locAssigned && granted && !beenSeized));
  assert_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.locRelease |=> (!locAssigned && !granted));
  // R2: ready request leaves idle clear
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.goReady |=> !idleBit);
endmodule

// File: rtl/crb_ctrl_regs.sv
module crb_ctrl_regs
  import crb_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0000_1000,
  parameter logic [31:0] BUF_OFFSET = 32'h0000_0080,
  parameter logic [3:0]  IF_REV     = 4'd0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  input  logic [1:0]         busWrSize,
  output logic [31:0]        busRdData,
  input  logic               estFlag,
  output logic               deliverCmd,
  output logic               cancelCmd,
  input  logic               cmdDone,
  input  logic               cmdErr
);
  ctrlStrobes_t strobes;
  logic         startBit;
  logic         locAssigned;
  logic [2:0]   activeLoc;

  crb_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busWrSize(busWrSize), .startBit(startBit),
    .locAssigned(locAssigned), .activeLoc(activeLoc), .cmdDone(cmdDone),
    .strobes(strobes), .deliverCmd(deliverCmd), .cancelCmd(cancelCmd)
  );

  crb_regs #(.WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
             .BUF_OFFSET(BUF_OFFSET), .IF_REV(IF_REV)) regs_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdDone(cmdDone),
    .cmdErr(cmdErr), .estFlag(estFlag), .rdOffset(busAddr[11:0]),
    .busRdData(busRdData), .startBit(startBit),
    .locAssigned(locAssigned), .activeLoc(activeLoc)
  );
endmodule

// File: tb/crb_ctrl_regs_tb_top.sv
module crb_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [1:0]  busWrSize = 2'd3;
  logic [31:0] busRdData;
  logic        estFlag = 1'b1;
  logic        deliverCmd;
  logic        cancelCmd;
  logic        cmdDone = 1'b0;
  logic        cmdErr = 1'b0;

  int checks = 0;
  int errors = 0;
  logic sawDel, sawCan;

  always #4 clk = ~clk;

  crb_ctrl_regs dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busWrSize(busWrSize), .busRdData(busRdData),
    .estFlag(estFlag), .deliverCmd(deliverCmd), .cancelCmd(cancelCmd),
    .cmdDone(cmdDone), .cmdErr(cmdErr)
  );

  // {wr, req, addr, data, size, expect}
  localparam int NV = 41;
  localparam logic [86:0] VEC [NV] = '{
    {1'b0, 4'd1,  16'h0000, 32'h0,        2'd3, 32'h0000_0080}, // R1
    {1'b0, 4'd1,  16'h000C, 32'h0,        2'd3, 32'h0},         // R1
    {1'b0, 4'd1,  16'h0044, 32'h0,        2'd3, 32'h2},         // R1
    {1'b0, 4'd1,  16'h0030, 32'h0,        2'd3, 32'h0002_5811}, // R1
    {1'b0, 4'd1,  16'h0058, 32'h0,        2'd3, 32'h0000_0F80}, // R1
    {1'b0, 4'd1,  16'h005C, 32'h0,        2'd3, 32'h8000_0080}, // R1
    {1'b0, 4'd1,  16'h0064, 32'h0,        2'd3, 32'h0000_0F80}, // R1
    {1'b0, 4'd1,  16'h0068, 32'h0,        2'd3, 32'h8000_0080}, // R1
    {1'b0, 4'd1,  16'h004C, 32'h0,        2'd3, 32'h0},         // R1
    {1'b0, 4'd10, 16'h0010, 32'h0,        2'd3, 32'h0},         // R10
    {1'b1, 4'd10, 16'h0030, 32'hFFFF_FFFF, 2'd3, 32'h0},        // R10
    {1'b0, 4'd10, 16'h0030, 32'h0,        2'd3, 32'h0002_5811}, // R10
    {1'b1, 4'd10, 16'h0058, 32'h0,        2'd3, 32'h0},         // R10
    {1'b0, 4'd10, 16'h0058, 32'h0,        2'd3, 32'h0000_0F80}, // R10
    {1'b0, 4'd8,  16'h0031, 32'h0,        2'd3, 32'h0000_0258}, // R8
    {1'b0, 4'd8,  16'h0032, 32'h0,        2'd3, 32'h0000_0002}, // R8
    {1'b0, 4'd8,  16'h0033, 32'h0,        2'd3, 32'h0},         // R8
    {1'b0, 4'd8,  16'h005D, 32'h0,        2'd3, 32'h0080_0000}, // R8
    {1'b1, 4'd2,  16'h0040, 32'h1,        2'd3, 32'h0},         // R2
    {1'b0, 4'd2,  16'h0044, 32'h0,        2'd3, 32'h0},         // R2
    {1'b1, 4'd2,  16'h0040, 32'h3,        2'd3, 32'h0},         // R2
    {1'b0, 4'd2,  16'h0044, 32'h0,        2'd3, 32'h0},         // R2
    {1'b1, 4'd2,  16'h0040, 32'h2,        2'd3, 32'h0},         // R2
    {1'b0, 4'd2,  16'h0044, 32'h0,        2'd3, 32'h2},         // R2
    {1'b1, 4'd11, 16'h0040, 32'hAB01,     2'd0, 32'h0},         // R11
    {1'b0, 4'd11, 16'h0044, 32'h0,        2'd3, 32'h0},         // R11
    {1'b1, 4'd11, 16'h0040, 32'h0102,     2'd1, 32'h0},         // R11
    {1'b0, 4'd11, 16'h0044, 32'h0,        2'd3, 32'h0},         // R11
    {1'b1, 4'd2,  16'h0040, 32'h2,        2'd3, 32'h0},         // R2
    {1'b0, 4'd2,  16'h0044, 32'h0,        2'd3, 32'h2},         // R2
    {1'b1, 4'd3,  16'h0008, 32'h1,        2'd3, 32'h0},         // R3
    {1'b0, 4'd3,  16'h000C, 32'h0,        2'd3, 32'h1},         // R3
    {1'b0, 4'd3,  16'h0000, 32'h0,        2'd3, 32'h82},        // R3
    {1'b1, 4'd3,  16'h0008, 32'h4,        2'd3, 32'h0},         // R3
    {1'b0, 4'd3,  16'h0000, 32'h0,        2'd3, 32'h82},        // R3
    {1'b1, 4'd3,  16'h0008, 32'h8,        2'd3, 32'h0},         // R3
    {1'b0, 4'd3,  16'h0000, 32'h0,        2'd3, 32'h82},        // R3
    {1'b0, 4'd3,  16'h000C, 32'h0,        2'd3, 32'h1},         // R3
    {1'b1, 4'd3,  16'h0008, 32'h2,        2'd3, 32'h0},         // R3
    {1'b0, 4'd3,  16'h000C, 32'h0,        2'd3, 32'h0},         // R3
    {1'b0, 4'd3,  16'h0000, 32'h0,        2'd3, 32'h80}         // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] s);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busWrSize = s;
    @(negedge clk);
    busWrEn = 1'b0;
    sawDel = deliverCmd;
    sawCan = cancelCmd;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic complete(input logic e);
    @(negedge clk);
    cmdDone = 1'b1; cmdErr = e;
    @(negedge clk);
    cmdDone = 1'b0; cmdErr = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][86]) wr(VEC[i][81:66], VEC[i][65:34], VEC[i][33:32]);
      else begin
        rd(VEC[i][81:66], v);
        check($sformatf("R%0d row %0d", VEC[i][85:82], i), v, VEC[i][31:0]);
      end
    end

    // R9: established flag inverted into bit 0
    estFlag = 1'b0;
    rd(16'h0000, v); check("R9", v, 32'h81);
    estFlag = 1'b1;
    rd(16'h0000, v); check("R9", v, 32'h80);

    // R7: no owner -> start rejected
    wr(16'h004C, 32'h1, 2'd3); check("R7 no owner deliver", {31'd0, sawDel}, 32'h0);
    rd(16'h004C, v); check("R7 start bit", v, 32'h0);
    wr(16'h0008, 32'h1, 2'd3);
    wr(16'h104C, 32'h1, 2'd3); check("R7 foreign page deliver", {31'd0, sawDel}, 32'h0);

    // R5: cancel when nothing in flight
    wr(16'h0048, 32'h1, 2'd3); check("R5 idle cancel", {31'd0, sawCan}, 32'h0);
    // R4: wrong value
    wr(16'h004C, 32'h3, 2'd3); check("R4 bad value", {31'd0, sawDel}, 32'h0);
    // R4: accepted start
    wr(16'h004C, 32'h1, 2'd3); check("R4 deliver", {31'd0, sawDel}, 32'h1);
    @(negedge clk); check("R4 deliver width", {31'd0, deliverCmd}, 32'h0);
    rd(16'h004C, v); check("R4 start bit set", v, 32'h1);
    wr(16'h004C, 32'h1, 2'd3); check("R4 busy restart", {31'd0, sawDel}, 32'h0);
    // R5: cancel value and legal cancel
    wr(16'h0048, 32'h2, 2'd3); check("R5 bad value", {31'd0, sawCan}, 32'h0);
    wr(16'h0048, 32'h1, 2'd3); check("R5 cancel", {31'd0, sawCan}, 32'h1);
    @(negedge clk); check("R5 cancel width", {31'd0, cancelCmd}, 32'h0);
    // R6: clean completion
    complete(1'b0);
    rd(16'h004C, v); check("R6 start cleared", v, 32'h0);
    rd(16'h0044, v); check("R6 no fatal", v, 32'h2);
    // R6: error completion
    wr(16'h004C, 32'h1, 2'd3); check("R6 second deliver", {31'd0, sawDel}, 32'h1);
    complete(1'b1);
    rd(16'h0044, v); check("R6 fatal set", v, 32'h3);
    rd(16'h004C, v); check("R6 start cleared err", v, 32'h0);

    // R12: start and completion together
    @(negedge clk);
    cmdDone = 1'b1; busWrEn = 1'b1; busAddr = 16'h004C; busWrData = 32'h1; busWrSize = 2'd3;
    @(negedge clk);
    cmdDone = 1'b0; busWrEn = 1'b0;
    check("R12 no deliver", {31'd0, deliverCmd}, 32'h0);
    rd(16'h004C, v); check("R12 start clear", v, 32'h0);

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(16'h0044, v); check("R1 reset status", v, 32'h2);
    rd(16'h000C, v); check("R1 reset loc sts", v, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule